// File: doc/BRIEF.md
# Refresh Collision Guard

This block sits next to a DRAM command timing checker. It receives a candidate command with its tentative earliest start cycle. If that start would collide with a coming refresh, the block moves it to just after the refresh. Deadlines are kept as absolute cycle numbers. Each time the scheduler reports that a refresh was issued, the matching deadline moves one refresh interval forward.

The block has three behaviours, chosen once at reset:

- **Off:** the start is passed through unchanged.
- **All-bank:** one shared deadline covers every bank.
- **Per-bank:** each bank has its own deadline, and the banks' deadlines start one cycle apart.

Each command kind has its own guard band in front of the forced precharge. A command that enters its band is moved to the refresh deadline plus the refresh cycle time. The block does not generate refresh commands.

Top module: `refresh_guard`

## Requirements
- R1: `mode_cfg` is captured on every clock edge while `rst_n` is low and then held. Encodings: 2'b00 off, 2'b01 all-bank, 2'b10 per-bank, 2'b11 behaves as off. Changes to `mode_cfg` after reset have no effect.
- R2: In off mode, `start_out` equals `start_in` for every command.
- R3: After reset in all-bank mode, the refresh deadline is T_REFI and the precharge deadline is T_REFI−T_RP.
- R4: An activate (`cmd_type` 2'b00) is moved when `start_in` ≥ precharge deadline − T_RAS.
- R5: A read (`cmd_type` 2'b01) is moved when `start_in` ≥ precharge deadline − T_RTP. A write (`cmd_type` 2'b10) is moved when `start_in` ≥ precharge deadline − (T_WL+T_CCD+T_WR).
- R6: A precharge (`cmd_type` 2'b11) is moved in all-bank mode when `start_in` ≥ precharge deadline. In per-bank mode it is never moved.
- R7: A moved command gets `start_out` = refresh deadline + T_RFC, whatever its `start_in`. A command that is not moved keeps `start_out` = `start_in`.
- R8: A `ref_valid` strobe adds T_REFI to the relevant refresh deadline, and the precharge deadline follows it. In all-bank mode `ref_bank` is ignored.
- R9: After reset in per-bank mode, bank i's refresh deadline is T_REFI−(N−1)+i. Its precharge deadline is that value minus max(N, T_RP), where N = NUM_BANKS.
- R10: In per-bank mode, a strobe advances only the deadlines of bank `ref_bank`.
- R11: `start_out` is combinational from the current inputs and the stored deadlines. A strobe takes effect from the cycle after the one in which it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_cfg | input | 2 | Static behaviour select, captured in reset |
| cmd_type | input | 2 | Candidate command kind |
| cmd_bank | input | BANK_W | Bank addressed by the candidate |
| start_in | input | TIME_W | Tentative earliest start cycle |
| ref_valid | input | 1 | A refresh was issued this cycle |
| ref_bank | input | BANK_W | Bank of the issued refresh (per-bank mode) |
| start_out | output | TIME_W | Adjusted earliest start cycle |

## Verification
Deadline advance and candidate evaluation can happen in the same cycle. This occurs when the refresh strobe is raised together with a candidate whose start lies in the old guard band but clear of the new one. The bench drives both at once and expects the output to show the moved value, computed from the old deadline, before the edge. After the edge, with the strobe dropped, it expects the same candidate to pass through, which proves the new deadline has been applied.

// File: rtl/rfg_pkg.sv
// Shared types for the refresh collision guard.
// Assumes the encodings are fixed by the requirements and are not changed per instance.
package rfg_pkg;
    typedef enum logic [1:0] {
        RFG_OFF  = 2'b00,
        RFG_ALL  = 2'b01,
        RFG_BANK = 2'b10,
        RFG_RSV  = 2'b11
    } rfg_mode_e;

    typedef enum logic [1:0] {
        CMD_ACT = 2'b00,
        CMD_RD  = 2'b01,
        CMD_WR  = 2'b10,
        CMD_PRE = 2'b11
    } rfg_cmd_e;

    function automatic int unsigned rfg_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/rfg_deadline_store.sv
// Holds the refresh deadlines: one shared register plus one register per bank.
// The per-bank registers reset to values staggered one cycle apart.
// Assumes NUM_BANKS is a power of two and at least 2, and T_REFI >= NUM_BANKS.
module rfg_deadline_store
    import rfg_pkg::*;
#(
    parameter int TIME_W    = 32,
    parameter int NUM_BANKS = 4,
    parameter int T_REFI    = 780,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rfg_mode_e         mode,
    input  logic              ref_valid,
    input  logic [BANK_W-1:0] ref_bank,
    input  logic [BANK_W-1:0] rd_bank,
    output logic [TIME_W-1:0] all_dl,
    output logic [TIME_W-1:0] bank_dl
);
    localparam logic [TIME_W-1:0] STEP = TIME_W'(T_REFI);

    logic [TIME_W-1:0] all_q;
    logic [TIME_W-1:0] dl_q [NUM_BANKS];

    // Shared deadline: reset to one interval, advance on every strobe in all-bank mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            all_q <= STEP;
        else if (ref_valid && mode == RFG_ALL)
            all_q <= all_q + STEP;
    end

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        localparam logic [TIME_W-1:0] INIT = TIME_W'(T_REFI - (NUM_BANKS - 1) + i);
        // Per-bank deadline: staggered reset, advance only when this bank is refreshed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dl_q[i] <= INIT;
            else if (ref_valid && mode == RFG_BANK && ref_bank == BANK_W'(i))
                dl_q[i] <= dl_q[i] + STEP;
        end
    end

    assign all_dl  = all_q;
    assign bank_dl = dl_q[rd_bank];
endmodule

// File: rtl/rfg_window_cmp.sv
// Decides whether a candidate falls in its guard band ahead of the forced
// precharge, and if so replaces its start with the refresh deadline plus tRFC.
// Purely combinational. Assumes the refresh deadline is at least the precharge offset.
module rfg_window_cmp
    import rfg_pkg::*;
#(
    parameter int TIME_W    = 32,
    parameter int NUM_BANKS = 4,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 8,
    parameter int T_RTP     = 2,
    parameter int T_WL      = 1,
    parameter int T_CCD     = 2,
    parameter int T_WR      = 3,
    parameter int T_RFC     = 18
) (
    input  rfg_mode_e         mode,
    input  rfg_cmd_e          cmd,
    input  logic [TIME_W-1:0] start_in,
    input  logic [TIME_W-1:0] ref_dl,
    output logic [TIME_W-1:0] start_out
);
    localparam logic [TIME_W-1:0] G_ACT    = TIME_W'(T_RAS);
    localparam logic [TIME_W-1:0] G_RD     = TIME_W'(T_RTP);
    localparam logic [TIME_W-1:0] G_WR     = TIME_W'(T_WL + T_CCD + T_WR);
    localparam logic [TIME_W-1:0] OFF_ALL  = TIME_W'(T_RP);
    localparam logic [TIME_W-1:0] OFF_BANK = TIME_W'(rfg_max(NUM_BANKS, T_RP));
    localparam logic [TIME_W-1:0] RFC      = TIME_W'(T_RFC);

    logic [TIME_W-1:0] guard;
    logic [TIME_W-1:0] pre_dl;
    logic [TIME_W:0]   reach;
    logic              active;
    logic              hit;

    // Guard band per command kind.
    always_comb begin
        unique case (cmd)
            CMD_ACT: guard = G_ACT;
            CMD_RD:  guard = G_RD;
            CMD_WR:  guard = G_WR;
            default: guard = '0;
        endcase
    end

    // Forced precharge deadline and whether this mode guards this command.
    always_comb begin
        pre_dl = ref_dl - ((mode == RFG_ALL) ? OFF_ALL : OFF_BANK);
        active = (mode == RFG_ALL) || (mode == RFG_BANK && cmd != CMD_PRE);
    end

    // Collision test without underflow: start + guard >= precharge deadline.
    always_comb begin
        reach     = {1'b0, start_in} + {1'b0, guard};
        hit       = active && (reach >= {1'b0, pre_dl});
        start_out = hit ? (ref_dl + RFC) : start_in;
    end
endmodule

// File: rtl/refresh_guard.sv
// Top of the refresh collision guard. Captures the mode in reset, keeps the
// deadlines and adjusts the candidate's earliest start against them.
// Assumes mode_cfg is static outside reset and NUM_BANKS is a power of two.
module refresh_guard
    import rfg_pkg::*;
#(
    parameter int TIME_W    = 32,
    parameter int NUM_BANKS = 4,
    parameter int T_REFI    = 780,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 8,
    parameter int T_RTP     = 2,
    parameter int T_WL      = 1,
    parameter int T_CCD     = 2,
    parameter int T_WR      = 3,
    parameter int T_RFC     = 18,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_cfg,
    input  logic [1:0]        cmd_type,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [TIME_W-1:0] start_in,
    input  logic              ref_valid,
    input  logic [BANK_W-1:0] ref_bank,
    output logic [TIME_W-1:0] start_out
);
    rfg_mode_e         mode_q;
    logic [TIME_W-1:0] all_dl;
    logic [TIME_W-1:0] bank_dl;
    logic [TIME_W-1:0] sel_dl;

    // Mode capture: follow mode_cfg during reset, hold afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= rfg_mode_e'(mode_cfg);
    end

    rfg_deadline_store #(
        .TIME_W(TIME_W), .NUM_BANKS(NUM_BANKS), .T_REFI(T_REFI)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .mode(mode_q),
        .ref_valid(ref_valid), .ref_bank(ref_bank), .rd_bank(cmd_bank),
        .all_dl(all_dl), .bank_dl(bank_dl)
    );

    // Deadline used for this candidate.
    always_comb sel_dl = (mode_q == RFG_ALL) ? all_dl : bank_dl;

    rfg_window_cmp #(
        .TIME_W(TIME_W), .NUM_BANKS(NUM_BANKS), .T_RP(T_RP), .T_RAS(T_RAS),
        .T_RTP(T_RTP), .T_WL(T_WL), .T_CCD(T_CCD), .T_WR(T_WR), .T_RFC(T_RFC)
    ) u_cmp (
        .mode(mode_q), .cmd(rfg_cmd_e'(cmd_type)), .start_in(start_in),
        .ref_dl(sel_dl), .start_out(start_out)
    );
endmodule

// File: rtl/rfg_guard_chk.sv
// Property checker for refresh_guard, attached by bind below.
// Observes ports plus the captured mode and the selected deadline.
module rfg_guard_chk
    import rfg_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int T_RFC  = 18
) (
    input logic              clk,
    input logic              rst_n,
    input rfg_mode_e         mode_q,
    input logic [1:0]        cmd_type,
    input logic [TIME_W-1:0] start_in,
    input logic [TIME_W-1:0] start_out,
    input logic              ref_valid,
    input logic [TIME_W-1:0] sel_dl
);
    p_off_passes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == RFG_OFF || mode_q == RFG_RSV) |-> start_out == start_in);

    p_bank_pre_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == RFG_BANK && cmd_type == 2'b11) |-> start_out == start_in);

    p_moved_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_out != start_in) |-> start_out == sel_dl + TIME_W'(T_RFC));

    p_mode_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mode_q));

    p_quiet_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(cmd_type) && $stable(start_in) && $stable(sel_dl) == $stable(sel_dl)
         && $stable(mode_q) && !$past(ref_valid) && $stable(sel_dl))
        |-> $stable(start_out));
endmodule

bind refresh_guard rfg_guard_chk #(.TIME_W(TIME_W), .T_RFC(T_RFC)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .cmd_type(cmd_type),
    .start_in(start_in), .start_out(start_out), .ref_valid(ref_valid),
    .sel_dl(sel_dl)
);

// File: tb/sim_refresh_guard.sv
`timescale 1ns/1ps
// Directed bench for refresh_guard with default parameters:
// T_REFI 780, T_RP 3, T_RAS 8, T_RTP 2, T_WL 1, T_CCD 2, T_WR 3, T_RFC 18, 4 banks.
module sim_refresh_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_cfg = 2'b00;
    logic [1:0]  cmd_type = 2'b00;
    logic [1:0]  cmd_bank = 2'b00;
    logic [31:0] start_in = '0;
    logic        ref_valid = 1'b0;
    logic [1:0]  ref_bank = 2'b00;
    logic [31:0] start_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    refresh_guard u0 (
        .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .cmd_type(cmd_type),
        .cmd_bank(cmd_bank), .start_in(start_in), .ref_valid(ref_valid),
        .ref_bank(ref_bank), .start_out(start_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] exp);
        n_vec++;
        if (start_out !== exp) begin
            n_bad++;
            $display("FAIL %s: start_out=%0d expected=%0d", req, start_out, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; mode_cfg = m; ref_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic probe(input string req, input logic [1:0] c, input logic [1:0] b,
                         input int s, input int exp);
        @(negedge clk);
        cmd_type = c; cmd_bank = b; start_in = 32'(s);
        #1 check(req, 32'(exp));
    endtask

    task automatic strobe(input logic [1:0] b);
        @(negedge clk);
        ref_valid = 1'b1; ref_bank = b;
        @(negedge clk);
        ref_valid = 1'b0;
    endtask

    task automatic t_off;
        do_reset(2'b00);
        probe("R2 off ACT", 2'b00, 2'd0, 769, 769);
        probe("R2 off WR", 2'b10, 2'd1, 5000, 5000);
        do_reset(2'b11);
        probe("R1 reserved acts as off", 2'b00, 2'd0, 800, 800);
    endtask

    task automatic t_all_bank;
        do_reset(2'b01);
        probe("R4 ACT before band", 2'b00, 2'd0, 768, 768);
        probe("R4 R3 ACT at band edge", 2'b00, 2'd0, 769, 798);
        probe("R5 RD before band", 2'b01, 2'd2, 774, 774);
        probe("R5 RD at band edge", 2'b01, 2'd2, 775, 798);
        probe("R5 WR before band", 2'b10, 2'd1, 770, 770);
        probe("R5 WR at band edge", 2'b10, 2'd1, 771, 798);
        probe("R6 PRE before deadline", 2'b11, 2'd0, 776, 776);
        probe("R6 R3 PRE at deadline", 2'b11, 2'd0, 777, 798);
        probe("R7 late ACT forced to target", 2'b00, 2'd0, 3000, 798);
        mode_cfg = 2'b00;
        probe("R1 mode change after reset ignored", 2'b00, 2'd0, 769, 798);
        strobe(2'd3);
        probe("R8 ACT clear after advance", 2'b00, 2'd0, 769, 769);
        probe("R8 ACT below new band", 2'b00, 2'd0, 1548, 1548);
        probe("R8 ACT in new band", 2'b00, 2'd0, 1549, 1578);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        cmd_type = 2'b00; cmd_bank = 2'd0; start_in = 32'd1549; ref_valid = 1'b1;
        #1 check("R11 strobe cycle uses old deadline", 32'd1578);
        @(negedge clk);
        ref_valid = 1'b0;
        #1 check("R11 next cycle uses new deadline", 32'd1549);
    endtask

    task automatic t_per_bank;
        do_reset(2'b10);
        probe("R9 bank0 ACT before band", 2'b00, 2'd0, 764, 764);
        probe("R9 bank0 ACT in band", 2'b00, 2'd0, 765, 795);
        probe("R9 bank3 ACT before band", 2'b00, 2'd3, 767, 767);
        probe("R9 bank3 ACT in band", 2'b00, 2'd3, 768, 798);
        probe("R5 R9 bank1 RD in band", 2'b01, 2'd1, 772, 796);
        probe("R5 R9 bank0 WR in band", 2'b10, 2'd0, 767, 795);
        probe("R6 per-bank PRE untouched", 2'b11, 2'd2, 5000, 5000);
        strobe(2'd1);
        probe("R10 bank1 clear after its refresh", 2'b00, 2'd1, 765, 765);
        probe("R10 bank1 in its new band", 2'b00, 2'd1, 1546, 1576);
        probe("R10 bank0 unchanged", 2'b00, 2'd0, 765, 795);
        probe("R10 bank2 unchanged", 2'b00, 2'd2, 767, 797);
    endtask

    initial begin
        t_off();
        t_all_bank();
        t_same_cycle();
        t_per_bank();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule